// File: doc/BRIEF.md
# Configurable CRC and Checksum Engine

The engine folds a stream of written words into a running CRC or ones'-complement checksum value. Software sets up a control register, optionally loads a starting value through the seed register, and then writes data words one at a time. Each data write updates the running value in the same clock edge. The running value is always visible raw, and a second output shows it after the selected output inversion and bit-order transforms.

Four CRC polynomials (two 16-bit, two 32-bit) and a 16-bit TCP-style checksum can be selected at run time. Input words can be taken whole (32 bits) or as a single low byte. Before processing, the engine can swap bytes within half-words, swap the half-words, and reverse the bit order inside every byte. A two-bit initialisation selector chooses where the first data write starts from: the seed register, all zeros or all ones. The selector clears itself once it has been used.

The register map uses write address 0 for control, 1 for the seed and 2 for data-in. A write to address 3 is ignored. The control register keeps only its defined fields, so every other bit reads as zero.

Top module: `crcsum_engine`

## Requirements
- R1: Control field [14:13] picks the start value for the next data write: 2'b10 starts from all zeros, 2'b11 from all ones, and 2'b00 or 2'b01 from the current running value (the seed register).
- R2: Every data write clears control field [14:13] to 2'b00. Later data writes then continue from the running value until software writes the field again.
- R3: Control bit 12 = 1 processes only data bits [7:0] as one byte. Control bit 12 = 0 processes all 32 bits.
- R4: Control bit 7 = 1 reverses the bit order inside every input byte before processing.
- R5: In 32-bit mode, control bit 4 = 1 swaps the two bytes of each half-word, and control bit 5 = 1 swaps the upper and lower half-words. Both apply before the bit reversal of R4.
- R6: Control field [3:0] selects the operation: 0 is CRC with polynomial 0x8005, 1 is CRC 0x1021, 2 is CRC 0x04C11DB7, 3 is CRC 0x1EDC6F41, and 8 is the checksum. CRCs shift the input most significant bit first, with no reflection. After a data write in a 16-bit mode (codes 0, 1, 8), bits [31:16] of the running value are zero.
- R7: Checksum mode adds the input into a 16-bit accumulator with end-around carry. In 32-bit mode it adds the upper half-word and then the lower one. In byte mode it adds the zero-extended byte.
- R8: A data write with any other operation code leaves the running value unchanged.
- R9: The post-processed output is the running value with every byte bit-reversed when control bit 8 = 1, then inverted when control bit 9 = 1. Bits [31:16] are forced to zero in 16-bit modes. These bits never alter the running value.
- R10: A seed write loads the running value. The running value changes only on seed or data writes, and both outputs show the effect of a write one clock after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register select: 0 control, 1 seed, 2 data-in |
| wr_data | input | 32 | Write data |
| ctrl_o | output | 32 | Control register contents |
| raw_o | output | 32 | Running CRC or checksum value (seed register) |
| post_o | output | 32 | Post-processed running value |

## Verification
A corrupted running value cannot hide: `raw_o` shows it one clock after the write that caused it, and `post_o` shows it on that same clock. The same wrong value then carries into every later result. A stuck or lingering initialisation selector shows up on `ctrl_o` right after the data write. It also appears as a wrong start value, which known-answer sequences over the ASCII digits 1 through 9 expose at once. An input transform that is applied when it should not be, or skipped when it should apply, gives a result that differs from a bench-side model on the first write.

// File: rtl/crcsum_pkg.sv
package crcsum_pkg;
  localparam int CW = 32;

  localparam int F_INIT_LO = 13;
  localparam int F_BYTE    = 12;
  localparam int F_OINV    = 9;
  localparam int F_OREV    = 8;
  localparam int F_IREV    = 7;
  localparam int F_HSWAP   = 5;
  localparam int F_BSWAP   = 4;
  localparam logic [CW-1:0] CTRL_MASK = 32'h0000_73BF;

  typedef enum logic [3:0] {
    OP_CRC16_A = 4'h0,
    OP_CRC16_B = 4'h1,
    OP_CRC32_A = 4'h2,
    OP_CRC32_B = 4'h3,
    OP_SUM16   = 4'h8
  } op_e;

  function automatic logic [CW-1:0] rev_each_byte(input logic [CW-1:0] v);
    logic [CW-1:0] r;
    for (int b = 0; b < CW/8; b++)
      for (int k = 0; k < 8; k++)
        r[8*b+k] = v[8*b+7-k];
    return r;
  endfunction

  function automatic logic narrow_op(input logic [3:0] op);
    return (op == OP_CRC16_A) || (op == OP_CRC16_B) || (op == OP_SUM16);
  endfunction

  function automatic logic known_op(input logic [3:0] op);
    return narrow_op(op) || (op == OP_CRC32_A) || (op == OP_CRC32_B);
  endfunction

  function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'h0, s[16]};
  endfunction
endpackage

// File: rtl/crcsum_in_xform.sv
module crcsum_in_xform
  import crcsum_pkg::*;
(
  input  logic [CW-1:0] din,
  input  logic          byte_mode,
  input  logic          bswap,
  input  logic          hswap,
  input  logic          irev,
  output logic [CW-1:0] word
);
  logic [CW-1:0] w;

  always_comb begin
    w = din;
    if (bswap) w = {w[23:16], w[31:24], w[7:0], w[15:8]};
    if (hswap) w = {w[15:0], w[31:16]};
    if (byte_mode) w = {24'h0, din[7:0]};
    if (irev) w = rev_each_byte(w);
    word = w;
  end
endmodule

// File: rtl/crcsum_step.sv
module crcsum_step
  import crcsum_pkg::*;
#(
  parameter logic [CW-1:0] POLY16_A = 32'h0000_8005,
  parameter logic [CW-1:0] POLY16_B = 32'h0000_1021,
  parameter logic [CW-1:0] POLY32_A = 32'h04C1_1DB7,
  parameter logic [CW-1:0] POLY32_B = 32'h1EDC_6F41
) (
  input  logic [3:0]    op,
  input  logic          byte_mode,
  input  logic [CW-1:0] start,
  input  logic [CW-1:0] word,
  output logic [CW-1:0] nxt
);
  logic [CW-1:0] c, w, poly;
  logic          fb, nar;
  logic [15:0]   acc;
  int            nb;

  always_comb begin
    c    = start;
    nar  = narrow_op(op);
    w    = byte_mode ? {word[7:0], 24'h0} : word;
    nb   = byte_mode ? 8 : CW;
    acc  = 16'h0;
    fb   = 1'b0;
    case (op)
      OP_CRC16_A: poly = POLY16_A;
      OP_CRC16_B: poly = POLY16_B;
      OP_CRC32_A: poly = POLY32_A;
      default:    poly = POLY32_B;
    endcase
    if (op == OP_SUM16) begin
      acc = oc_add(start[15:0], byte_mode ? {8'h0, word[7:0]} : word[31:16]);
      if (!byte_mode) acc = oc_add(acc, word[15:0]);
      nxt = {16'h0, acc};
    end else begin
      for (int i = 0; i < CW; i++) begin
        if (i < nb) begin
          fb = (nar ? c[15] : c[CW-1]) ^ w[CW-1-i];
          c  = {c[CW-2:0], 1'b0} ^ (fb ? poly : '0);
        end
      end
      nxt = nar ? {16'h0, c[15:0]} : c;
    end
  end
endmodule

// File: rtl/crcsum_post.sv
module crcsum_post
  import crcsum_pkg::*;
(
  input  logic [CW-1:0] raw,
  input  logic          oinv,
  input  logic          orev,
  input  logic          nar,
  output logic [CW-1:0] pp
);
  logic [CW-1:0] t;

  always_comb begin
    t = raw;
    if (orev) t = rev_each_byte(t);
    if (oinv) t = ~t;
    if (nar)  t[31:16] = 16'h0;
    pp = t;
  end
endmodule

// File: rtl/crcsum_engine.sv
module crcsum_engine
  import crcsum_pkg::*;
#(
  parameter int            AW       = 2,
  parameter logic [CW-1:0] POLY16_A = 32'h0000_8005,
  parameter logic [CW-1:0] POLY16_B = 32'h0000_1021,
  parameter logic [CW-1:0] POLY32_A = 32'h04C1_1DB7,
  parameter logic [CW-1:0] POLY32_B = 32'h1EDC_6F41
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] ctrl_o,
  output logic [CW-1:0] raw_o,
  output logic [CW-1:0] post_o
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_SEED = AW'(1);
  localparam logic [AW-1:0] A_DATA = AW'(2);

  logic [CW-1:0] ctrl_q, raw_q, post_q;
  logic [CW-1:0] ctrl_d, raw_d, post_d;
  logic [CW-1:0] start, start_m, word, step_nxt;
  logic [3:0]    op;
  logic [1:0]    init_sel;
  logic          data_wr;

  assign op       = ctrl_q[3:0];
  assign init_sel = ctrl_q[F_INIT_LO+1:F_INIT_LO];
  assign data_wr  = wr_en && (wr_addr == A_DATA);

  always_comb begin
    case (init_sel)
      2'b10:   start = '0;
      2'b11:   start = '1;
      default: start = raw_q;
    endcase
    start_m = narrow_op(op) ? {16'h0, start[15:0]} : start;
  end

  crcsum_in_xform u_in (
    .din       (wr_data),
    .byte_mode (ctrl_q[F_BYTE]),
    .bswap     (ctrl_q[F_BSWAP]),
    .hswap     (ctrl_q[F_HSWAP]),
    .irev      (ctrl_q[F_IREV]),
    .word      (word)
  );

  crcsum_step #(
    .POLY16_A (POLY16_A),
    .POLY16_B (POLY16_B),
    .POLY32_A (POLY32_A),
    .POLY32_B (POLY32_B)
  ) u_step (
    .op        (op),
    .byte_mode (ctrl_q[F_BYTE]),
    .start     (start_m),
    .word      (word),
    .nxt       (step_nxt)
  );

  always_comb begin
    ctrl_d = ctrl_q;
    raw_d  = raw_q;
    if (wr_en) begin
      case (wr_addr)
        A_CTRL: ctrl_d = wr_data & CTRL_MASK;
        A_SEED: raw_d  = wr_data;
        A_DATA: begin
          if (known_op(op)) raw_d = step_nxt;
          ctrl_d[F_INIT_LO+1:F_INIT_LO] = 2'b00;
        end
        default: ;
      endcase
    end
  end

  crcsum_post u_post (
    .raw  (raw_d),
    .oinv (ctrl_d[F_OINV]),
    .orev (ctrl_d[F_OREV]),
    .nar  (narrow_op(ctrl_d[3:0])),
    .pp   (post_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      raw_q  <= '0;
      post_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      raw_q  <= raw_d;
      post_q <= post_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign raw_o  = raw_q;
  assign post_o = post_q;

  AST_INIT_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    data_wr |=> (ctrl_q[F_INIT_LO+1:F_INIT_LO] == 2'b00)); // R2
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (data_wr && narrow_op(op)) |=> (raw_q[31:16] == 16'h0)); // R6
  AST_UNUSED_OP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (data_wr && !known_op(op)) |=> $stable(raw_q)); // R8
  AST_POST_NARROW_MASK: assert property (@(posedge clk) disable iff (rst)
    narrow_op(ctrl_q[3:0]) |-> (post_q[31:16] == 16'h0)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(raw_q) && $stable(ctrl_q))); // R10
endmodule

// File: tb/tb_crcsum_engine.sv
module tb_crcsum_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [31:0] wr_data = 32'h0;
  logic [31:0] ctrl_o, raw_o, post_o;

  int tests = 0;
  int fails = 0;
  logic [31:0] m_ctrl = 32'h0;
  logic [31:0] m_raw  = 32'h0;

  always #10 clk = ~clk;

  crcsum_engine dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl_o(ctrl_o), .raw_o(raw_o), .post_o(post_o)
  );

  // rows: {ctrl, seed, data0, data1}
  localparam logic [127:0] VEC [8] = '{
    {32'h0000_0002, 32'hFFFF_FFFF, 32'h1234_5678, 32'hDEAD_BEEF},
    {32'h0000_00B3, 32'h0000_0000, 32'hA5C3_0F11, 32'h00FF_1234},
    {32'h0000_1000, 32'h0000_1234, 32'h0000_00C7, 32'h0000_003E},
    {32'h0000_0011, 32'h0000_FFFF, 32'hCAFE_F00D, 32'h1357_9BDF},
    {32'h0000_0008, 32'h0000_0000, 32'h4500_0073, 32'h0000_4000},
    {32'h0000_1088, 32'h0000_F0F0, 32'h0000_00AB, 32'h0000_00CD},
    {32'h0000_0302, 32'h0123_4567, 32'h89AB_CDEF, 32'h7654_3210},
    {32'h0000_6003, 32'h0000_0055, 32'h1111_1111, 32'h2222_2222}
  };

  function automatic string row_tag(input int i);
    case (i)
      0: return "R6";
      1: return "R4";
      2: return "R3";
      3: return "R5";
      4: return "R7";
      5: return "R7";
      6: return "R9";
      default: return "R1";
    endcase
  endfunction

  function automatic logic is16(input logic [31:0] c);
    return (c[3:0] == 4'd0) || (c[3:0] == 4'd1) || (c[3:0] == 4'd8);
  endfunction

  function automatic logic [31:0] m_in(input logic [31:0] c, input logic [31:0] d);
    logic [7:0] by [4];
    logic [7:0] t;
    logic [31:0] r;
    for (int k = 0; k < 4; k++) by[k] = d[8*k +: 8];
    if (c[12]) begin
      by[1] = 8'h0; by[2] = 8'h0; by[3] = 8'h0;
    end else begin
      if (c[4]) begin
        t = by[0]; by[0] = by[1]; by[1] = t;
        t = by[2]; by[2] = by[3]; by[3] = t;
      end
      if (c[5]) begin
        t = by[0]; by[0] = by[2]; by[2] = t;
        t = by[1]; by[1] = by[3]; by[3] = t;
      end
    end
    for (int k = 0; k < 4; k++) begin
      t = by[k];
      if (c[7]) for (int j = 0; j < 8; j++) by[k][j] = t[7-j];
    end
    r = {by[3], by[2], by[1], by[0]};
    return r;
  endfunction

  function automatic logic [31:0] m_step(input logic [31:0] c, input logic [31:0] acc,
                                          input logic [31:0] d);
    logic [31:0] x, p, s;
    int n, top;
    x = m_in(c, d);
    n = c[12] ? 8 : 32;
    case (c[3:0])
      4'd0: p = 32'h8005;
      4'd1: p = 32'h1021;
      4'd2: p = 32'h04C11DB7;
      4'd3: p = 32'h1EDC6F41;
      default: p = 32'h0;
    endcase
    if (c[3:0] == 4'd8) begin
      s = {16'h0, acc[15:0]} + (c[12] ? x[15:0] : ({16'h0, x[31:16]} + {16'h0, x[15:0]}));
      while (s[31:16] != 16'h0) s = {16'h0, s[15:0]} + {16'h0, s[31:16]};
      return s;
    end
    top = is16(c) ? 15 : 31;
    s = acc;
    for (int i = n - 1; i >= 0; i--) begin
      if (s[top] ^ x[i]) s = (s << 1) ^ p;
      else s = s << 1;
    end
    if (is16(c)) s[31:16] = 16'h0;
    return s;
  endfunction

  function automatic logic [31:0] m_post(input logic [31:0] c, input logic [31:0] r);
    logic [31:0] v;
    v = r;
    if (c[8]) for (int k = 0; k < 32; k++) v[k] = r[(k/8)*8 + 7 - (k%8)];
    if (c[9]) v = ~v;
    if (is16(c)) v[31:16] = 16'h0;
    return v;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    logic [31:0] st;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      2'd0: m_ctrl = d & 32'h0000_73BF;
      2'd1: m_raw = d;
      2'd2: begin
        st = (m_ctrl[14:13] == 2'b10) ? 32'h0 :
             (m_ctrl[14:13] == 2'b11) ? 32'hFFFF_FFFF : m_raw;
        if (is16(m_ctrl)) st[31:16] = 16'h0;
        if (is16(m_ctrl) || m_ctrl[3:0] == 4'd2 || m_ctrl[3:0] == 4'd3)
          m_raw = m_step(m_ctrl, st, d);
        m_ctrl[14:13] = 2'b00;
      end
      default: ;
    endcase
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic digits(input logic [31:0] c);
    wr(2'd0, c);
    for (int k = 1; k <= 9; k++) wr(2'd2, 32'h30 + k);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    chk("reset ctrl", ctrl_o, 32'h0);
    chk("reset raw R10", raw_o, 32'h0);
    chk("reset post", post_o, 32'h0);

    for (int i = 0; i < 8; i++) begin
      wr(2'd0, VEC[i][127:96]);
      wr(2'd1, VEC[i][95:64]);
      wr(2'd2, VEC[i][63:32]);
      wr(2'd2, VEC[i][31:0]);
      chk({row_tag(i), " table raw"}, raw_o, m_raw);
      chk({row_tag(i), " table post"}, post_o, m_post(m_ctrl, m_raw));
      chk({row_tag(i), " table ctrl R2"}, ctrl_o, m_ctrl);
    end

    // R7 known sum
    wr(2'd0, 32'h0000_0008); wr(2'd1, 32'h0);
    wr(2'd2, 32'h4500_0073); wr(2'd2, 32'h0000_4000);
    chk("R7 sum", raw_o, 32'h0000_8573);
    // R7 end-around carry from all-ones start (R1)
    wr(2'd0, 32'h0000_6008); wr(2'd2, 32'h0000_0002);
    chk("R7 end-around", raw_o, 32'h0000_0002);

    // R6/R3/R1 known answers over ASCII digits
    digits(32'h0000_7002);
    chk("R6 crc32 known", raw_o, 32'h0376_E6E7);
    chk("R2 init cleared", ctrl_o, 32'h0000_1002);
    // R9 post only; raw untouched
    wr(2'd0, 32'h0000_0302);
    chk("R9 post inv+rev", post_o, 32'h3F91_9818);
    chk("R9 raw unchanged", raw_o, 32'h0376_E6E7);

    digits(32'h0000_7001);
    chk("R6 crc16 1021 known", raw_o, 32'h0000_29B1);
    wr(2'd0, 32'h0000_0201);
    chk("R9 narrow invert", post_o, 32'h0000_D64E);

    digits(32'h0000_5000);
    chk("R1 zero start 8005 known", raw_o, 32'h0000_FEE8);

    // R1 zeros start ignores seed
    wr(2'd0, 32'h0000_4002); wr(2'd1, 32'hDEAD_BEEF); wr(2'd2, 32'h0);
    chk("R1 zero start", raw_o, 32'h0);

    // R8 unused op
    wr(2'd1, 32'hA5A5_5A5A); wr(2'd0, 32'h0000_6005); wr(2'd2, 32'h1234_5678);
    chk("R8 unused op raw", raw_o, 32'hA5A5_5A5A);
    chk("R8 init still cleared", ctrl_o, 32'h0000_0005);

    // R10 write to unmapped address ignored
    wr(2'd3, 32'hFFFF_FFFF);
    chk("R10 addr3 raw", raw_o, 32'hA5A5_5A5A);
    chk("R10 addr3 ctrl", ctrl_o, 32'h0000_0005);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule